// File: doc/BRIEF.md
# Shared Interrupt Claim and Completion Controller

This block gathers level-sensitive interrupt requests from a set of device sources and distributes them to several hart contexts. Each context has one external-interrupt line. Software sets a priority for every source, and for every context it sets an enable mask and a threshold, all through a small register port. A source can interrupt a context only when the context has it enabled and the source's priority is strictly above the context's threshold.

Each context also has a claim/complete port of its own. A claim read returns the identifier of the best qualifying pending source, or zero when no source qualifies. The claimed source then belongs to that context only. It stays out of service for every context until the context writes the same identifier back as a completion. After that, a request that is still held high is latched as pending again. If two contexts claim in the same cycle, the lower-numbered context is served first and the other context receives the next candidate.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, every priority, enable mask and threshold reads 0, every interrupt line is low and a claim read returns 0.
- R2: Register port (word addresses): address 1..31 holds the 3-bit priority of that source; address 0 reads 0 and ignores writes; address 32+2c holds the enable mask of context c (bit i enables source i, bit 0 always reads 0); address 33+2c holds the 3-bit threshold of context c. Read data appears one clock edge after the read strobe.
- R3: A source whose request is high and which is not in service becomes pending at the next edge. A context's interrupt line goes high at the second edge after the request rises, and it goes low one edge after the claim that removes its last qualifying source.
- R4: A pending source does not raise the line of a context, and is not claimed by it, if its priority is not above that context's threshold or if the context has not enabled it. Priority 0 never interrupts.
- R5: A claim read returns the qualifying pending source with the highest priority, ties going to the lowest identifier. The identifier is valid one edge after the read strobe, and the source stops being pending at that edge.
- R6: A claim read with no qualifying pending source returns 0.
- R7: A claimed source is not pending and cannot be claimed again until it is completed, even while its request stays high.
- R8: A completion write of an identifier that is in service and enabled for the writing context returns the source to idle. If its request is still high, it is pending again at the next edge.
- R9: A completion write of an identifier that is not in service, or that the writing context has not enabled, changes nothing.
- R10: When two contexts claim in the same cycle, the lower-numbered context receives its best source and the other context receives its best among the rest, or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 31 | Level requests; bit k belongs to source k+1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, registered |
| ctx_claim_rd | input | 2 | Claim read strobe, one per context |
| ctx_claim_id | output | 10 | Claimed identifier, 5 bits per context |
| ctx_done_wr | input | 2 | Completion write strobe, one per context |
| ctx_done_id | input | 10 | Completion identifier, 5 bits per context |
| ctx_irq | output | 2 | External-interrupt line, one per context |

## Verification
Register reads and claim identifiers are due one rising edge after their strobe. A request becomes pending after one edge and reaches the interrupt line after a second edge. A completed source that is still requesting re-latches one edge after the completion. The bench drives every input on a falling edge and reads results on the falling edge that follows the edge that produces them. It checks interrupt levels only after three quiet cycles, by which time every pending bit and line has settled. It also checks the interrupt-line timing directly, one and two edges after a request rises.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    CFG_NONE,
    CFG_PRIO,
    CFG_EN,
    CFG_THR
  } cfg_kind_e;

  typedef struct packed {
    cfg_kind_e  kind;
    logic [7:0] idx;
  } cfg_dec_t;

  // Word map: priorities at 0..nsrc, then enable/threshold pairs per context.
  function automatic cfg_dec_t decode(int unsigned addr, int unsigned nsrc,
                                      int unsigned nctx);
    cfg_dec_t d;
    int unsigned off;
    d.kind = CFG_NONE;
    d.idx  = '0;
    if (addr <= nsrc) begin
      d.kind = CFG_PRIO;
      d.idx  = 8'(addr);
    end else begin
      off = addr - (nsrc + 1);
      if (off < 2 * nctx) begin
        d.kind = off[0] ? CFG_THR : CFG_EN;
        d.idx  = 8'(off >> 1);
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic                          cfg_re,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic [NSRC:0][PRIO_W-1:0]     prio_o,
  output logic [NCTX-1:0][NSRC:0]       en_o,
  output logic [NCTX-1:0][PRIO_W-1:0]   thr_o
);
  import irqc_pkg::*;

  localparam int SW = $clog2(NSRC + 1);
  localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [NSRC:0][PRIO_W-1:0]   prio_q;
  logic [NCTX-1:0][NSRC:0]     en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  cfg_dec_t                    dec;
  logic [SW-1:0]               si;
  logic [CW-1:0]               ci;

  assign dec = decode(int'(cfg_addr), NSRC, NCTX);
  assign si  = dec.idx[SW-1:0];
  assign ci  = dec.idx[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      case (dec.kind)
        CFG_PRIO: if (si != '0) prio_q[si] <= cfg_wdata[PRIO_W-1:0];
        CFG_EN:   en_q[ci]  <= {cfg_wdata[NSRC:1], 1'b0};
        CFG_THR:  thr_q[ci] <= cfg_wdata[PRIO_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_re) begin
      case (dec.kind)
        CFG_PRIO: cfg_rdata <= DATA_W'(prio_q[si]);
        CFG_EN:   cfg_rdata <= DATA_W'(en_q[ci]);
        CFG_THR:  cfg_rdata <= DATA_W'(thr_q[ci]);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign thr_o  = thr_q;

endmodule

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter int NSRC = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NSRC:0] req,
  input  logic [NSRC:0] claim,
  input  logic [NSRC:0] done,
  output logic [NSRC:0] pend,
  output logic [NSRC:0] busy
);

  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    logic p_q;
    logic b_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= 1'b0;
        b_q <= 1'b0;
      end else if (claim[g]) begin
        p_q <= 1'b0;
        b_q <= 1'b1;
      end else if (done[g]) begin
        b_q <= 1'b0;
      end else if (req[g] && !b_q && !p_q) begin
        p_q <= 1'b1;
      end
    end
    assign pend[g] = p_q;
    assign busy[g] = b_q;
  end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic [NSRC:0]             avail,
  input  logic [NSRC:0]             en,
  input  logic [NSRC:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic [IDW-1:0]            best_id
);

  logic [PRIO_W-1:0] best_p;

  // Ascending scan with strict compare keeps the lowest ID on a tie.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (avail[i] && en[i] && (prio[i] > thr) && (prio[i] > best_p)) begin
        best_id = IDW'(i);
        best_p  = prio[i];
      end
    end
  end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NSRC + 1 + 2 * NCTX),
  parameter int IDW    = $clog2(NSRC + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        src_req,
  input  logic                   cfg_we,
  input  logic                   cfg_re,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  input  logic [NCTX-1:0]        ctx_claim_rd,
  output logic [NCTX*IDW-1:0]    ctx_claim_id,
  input  logic [NCTX-1:0]        ctx_done_wr,
  input  logic [NCTX*IDW-1:0]    ctx_done_id,
  output logic [NCTX-1:0]        ctx_irq
);

  localparam int NV = NSRC + 1;

  logic [NSRC:0]               req_v;
  logic [NSRC:0][PRIO_W-1:0]   prio_w;
  logic [NCTX-1:0][NSRC:0]     en_w;
  logic [NCTX-1:0][PRIO_W-1:0] thr_w;
  logic [NSRC:0]               pend_w;
  logic [NSRC:0]               busy_w;
  logic [NSRC:0]               claim_mask;
  logic [NSRC:0]               done_mask;
  logic [NCTX:0][NSRC:0]       avail;
  logic [NCTX-1:0][NSRC:0]     take;
  logic [NCTX-1:0][IDW-1:0]    best;

  assign req_v = {src_req, 1'b0};

  irqc_cfg_regs #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .prio_o(prio_w), .en_o(en_w), .thr_o(thr_w)
  );

  irqc_gateway #(.NSRC(NSRC)) u_gw (
    .clk(clk), .rst(rst), .req(req_v),
    .claim(claim_mask), .done(done_mask),
    .pend(pend_w), .busy(busy_w)
  );

  // Contexts are served in index order: each one sees what the lower ones left.
  assign avail[0] = pend_w;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic           irq_r;
    logic [IDW-1:0] id_r;

    irqc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
      .avail(avail[c]), .en(en_w[c]), .prio(prio_w), .thr(thr_w[c]),
      .best_id(best[c])
    );

    assign take[c] = (ctx_claim_rd[c] && (best[c] != '0))
                   ? (NV'(1) << best[c]) : '0;
    assign avail[c+1] = avail[c] & ~take[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_r <= 1'b0;
        id_r  <= '0;
      end else begin
        irq_r <= (best[c] != '0);
        if (ctx_claim_rd[c]) id_r <= best[c];
      end
    end

    assign ctx_irq[c]                  = irq_r;
    assign ctx_claim_id[c*IDW +: IDW]  = id_r;
  end

  always_comb begin
    claim_mask = '0;
    done_mask  = '0;
    for (int c = 0; c < NCTX; c++) begin
      claim_mask = claim_mask | take[c];
      for (int i = 1; i <= NSRC; i++) begin
        if (ctx_done_wr[c] && (ctx_done_id[c*IDW +: IDW] == IDW'(i)) &&
            busy_w[i] && en_w[c][i])
          done_mask[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_we,
  input logic [NCTX-1:0]             ctx_claim_rd,
  input logic [NCTX*IDW-1:0]         ctx_claim_id,
  input logic [NCTX-1:0]             ctx_irq,
  input logic [NSRC:0]               pend,
  input logic [NSRC:0]               busy,
  input logic [NSRC:0][PRIO_W-1:0]   prio,
  input logic [NCTX-1:0][PRIO_W-1:0] thr
);

  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctx_irq == '0)); // R1

  AST_PEND_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (pend & busy) == '0); // R7

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [IDW-1:0] cid;
    assign cid = ctx_claim_id[c*IDW +: IDW];

    AST_CLAIM_LEAVES_PEND: assert property (@(posedge clk) disable iff (rst)
      ctx_claim_rd[c] |=> (cid == '0 || !pend[cid])); // R7

    AST_CLAIM_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
      ctx_claim_rd[c] |=> (cid == '0 || busy[cid])); // R5

    AST_CLAIM_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
      (ctx_claim_rd[c] && !cfg_we) |=> (cid == '0 || prio[cid] > thr[c])); // R4

    if (c > 0) begin : g_pair
      AST_NO_DUAL_GRANT: assert property (@(posedge clk) disable iff (rst)
        (ctx_claim_rd[c] && ctx_claim_rd[c-1]) |=>
          (cid == '0 || cid != ctx_claim_id[(c-1)*IDW +: IDW])); // R10
    end
  end

endmodule

bind irq_claim_ctrl irqc_checks #(
  .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .IDW(IDW)
) u_checks (
  .clk(clk), .rst(rst), .cfg_we(cfg_we),
  .ctx_claim_rd(ctx_claim_rd), .ctx_claim_id(ctx_claim_id), .ctx_irq(ctx_irq),
  .pend(pend_w), .busy(busy_w), .prio(prio_w), .thr(thr_w)
);

// File: tb/test_irq_claim_ctrl.sv
`timescale 1ns/1ps
module test_irq_claim_ctrl;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam int IDW  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   src_req = '0;
  logic              cfg_we = 1'b0, cfg_re = 1'b0;
  logic [5:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0, cfg_rdata;
  logic [NCTX-1:0]   ctx_claim_rd = '0, ctx_done_wr = '0, ctx_irq;
  logic [NCTX*IDW-1:0] ctx_claim_id, ctx_done_id = '0;

  int nchk = 0, nfail = 0;
  int prio_m [32];
  bit [31:0] en_m [2];
  int thr_m [2];
  bit [31:0] req_m, pend_m, busy_m;

  always #2 clk = ~clk;

  irq_claim_ctrl i_irq_claim_ctrl (
    .clk(clk), .rst(rst), .src_req(src_req),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctx_claim_rd(ctx_claim_rd), .ctx_claim_id(ctx_claim_id),
    .ctx_done_wr(ctx_done_wr), .ctx_done_id(ctx_done_id), .ctx_irq(ctx_irq)
  );

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  function automatic int best(int c);
    int b = 0, bp = 0;
    for (int i = 1; i <= NSRC; i++)
      if (pend_m[i] && en_m[c][i] && prio_m[i] > thr_m[c] && prio_m[i] > bp) begin
        b = i; bp = prio_m[i];
      end
    return b;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_req = '0;
    req_m = '0; pend_m = '0; busy_m = '0;
    for (int i = 0; i < 32; i++) prio_m[i] = 0;
    en_m[0] = '0; en_m[1] = '0; thr_m[0] = 0; thr_m[1] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(int a, output int d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = 6'(a);
    @(negedge clk);
    cfg_re = 1'b0;
    d = int'(cfg_rdata);
  endtask

  task automatic set_prio(int id, int p);
    cfg_write(id, p); prio_m[id] = p;
  endtask
  task automatic set_en(int c, bit [31:0] m);
    cfg_write(32 + 2 * c, int'(m)); en_m[c] = m & 32'hFFFF_FFFE;
  endtask
  task automatic set_thr(int c, int t);
    cfg_write(33 + 2 * c, t); thr_m[c] = t;
  endtask

  task automatic set_req(bit [31:0] m);
    @(negedge clk);
    req_m = m & 32'hFFFF_FFFE;
    src_req = req_m[31:1];
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    pend_m = pend_m | (req_m & ~busy_m);
  endtask

  task automatic claim(int c, output int id);
    @(negedge clk);
    ctx_claim_rd[c] = 1'b1;
    @(negedge clk);
    ctx_claim_rd[c] = 1'b0;
    id = int'(ctx_claim_id[c*IDW +: IDW]);
    if (id != 0) begin pend_m[id] = 1'b0; busy_m[id] = 1'b1; end
  endtask

  task automatic claim2(output int a, output int b);
    @(negedge clk);
    ctx_claim_rd = 2'b11;
    @(negedge clk);
    ctx_claim_rd = 2'b00;
    a = int'(ctx_claim_id[0 +: IDW]);
    b = int'(ctx_claim_id[IDW +: IDW]);
    if (a != 0) begin pend_m[a] = 1'b0; busy_m[a] = 1'b1; end
    if (b != 0) begin pend_m[b] = 1'b0; busy_m[b] = 1'b1; end
  endtask

  task automatic complete(int c, int id);
    @(negedge clk);
    ctx_done_wr[c] = 1'b1;
    ctx_done_id[c*IDW +: IDW] = IDW'(id);
    @(negedge clk);
    ctx_done_wr[c] = 1'b0;
    if (busy_m[id] && en_m[c][id]) busy_m[id] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    finish_up();
  end

  initial begin
    int v, a, b, e0, e1, c;
    void'($urandom(32'd2024));

    // R1 reset state
    do_reset();
    cfg_read(5, v);  chk("R1 prio after reset", v, 0);
    cfg_read(32, v); chk("R1 enable after reset", v, 0);
    cfg_read(35, v); chk("R1 threshold after reset", v, 0);
    chk("R1 irq after reset", int'(ctx_irq), 0);
    claim(0, v);     chk("R1 claim after reset", v, 0);

    // R2 register map
    cfg_write(3, 6);             cfg_read(3, v);  chk("R2 prio readback", v, 6);
    cfg_write(0, 7);             cfg_read(0, v);  chk("R2 addr0 ignored", v, 0);
    cfg_write(32, 32'hFFFF_FFFF); cfg_read(32, v); chk("R2 enable bit0", v, 32'hFFFF_FFFE);
    cfg_write(35, 13);           cfg_read(35, v); chk("R2 threshold width", v, 5);

    // R3 interrupt line timing
    do_reset();
    set_prio(2, 1); set_en(0, 32'h4);
    @(negedge clk); src_req[1] = 1'b1; req_m[2] = 1'b1;
    @(negedge clk); chk("R3 irq one edge after req", int'(ctx_irq[0]), 0);
    @(negedge clk); chk("R3 irq two edges after req", int'(ctx_irq[0]), 1);
    pend_m[2] = 1'b1;
    claim(0, v); chk("R3 claim id", v, 2);
    @(negedge clk); chk("R3 irq drops after claim", int'(ctx_irq[0]), 0);

    // R4 threshold and enable masking
    do_reset();
    set_prio(7, 3); set_prio(8, 0);
    set_en(0, 32'h180); set_thr(0, 3);
    set_req(32'h180); settle();
    chk("R4 prio equal to thr masked", int'(ctx_irq[0]), 0);
    chk("R4 not enabled ctx1", int'(ctx_irq[1]), 0);
    claim(0, v); chk("R4 masked claim", v, 0);
    set_thr(0, 2); settle();
    chk("R4 irq after lowering thr", int'(ctx_irq[0]), 1);
    claim(0, v); chk("R4 claim above thr", v, 7);
    claim(0, v); chk("R4 prio0 never claimed", v, 0);

    // R5 R6 R7 priority order, tie break, empty claim, no reclaim
    do_reset();
    set_prio(4, 5); set_prio(9, 5); set_prio(12, 3);
    set_en(0, 32'h1210);
    set_req(32'h1210); settle();
    claim(0, v); chk("R5 tie lowest id", v, 4);
    claim(0, v); chk("R5 tie second", v, 9);
    claim(0, v); chk("R5 lower prio last", v, 12);
    claim(0, v); chk("R6 empty claim", v, 0);
    settle();
    chk("R7 irq low while in service", int'(ctx_irq[0]), 0);
    claim(0, v); chk("R7 no reclaim with req high", v, 0);

    // R9 ignored completions, R8 real completion
    set_en(1, 32'h200);
    complete(1, 4);  settle();
    claim(0, v); chk("R9 completion from non-enabled ctx", v, 0);
    complete(0, 20); settle();
    claim(0, v); chk("R9 completion of idle id", v, 0);
    complete(0, 4);  settle();
    chk("R8 irq back after completion", int'(ctx_irq[0]), 1);
    claim(0, v); chk("R8 re-armed source claimed", v, 4);

    // R10 simultaneous claims
    do_reset();
    set_prio(4, 5); set_prio(9, 5);
    set_en(0, 32'h210); set_en(1, 32'h210);
    set_req(32'h210); settle();
    claim2(a, b);
    chk("R10 ctx0 gets best", a, 4);
    chk("R10 ctx1 gets next", b, 9);
    set_req(32'h10);
    complete(0, 4); complete(1, 9); settle();
    claim2(a, b);
    chk("R10 ctx0 single source", a, 4);
    chk("R10 ctx1 gets zero", b, 0);

    // Random rounds against the bench model (R4 R5 R6 R8 R10)
    for (int r = 0; r < 8; r++) begin
      do_reset();
      for (int i = 1; i <= NSRC; i++) set_prio(i, int'($urandom % 8));
      set_en(0, $urandom); set_en(1, $urandom);
      set_thr(0, int'($urandom % 4)); set_thr(1, int'($urandom % 4));
      set_req($urandom); settle();
      chk("R4 random irq ctx0", int'(ctx_irq[0]), int'(best(0) != 0));
      chk("R4 random irq ctx1", int'(ctx_irq[1]), int'(best(1) != 0));
      for (int k = 0; k < 24; k++) begin
        if ($urandom % 4 == 0) begin
          e0 = best(0);
          if (e0 != 0) pend_m[e0] = 1'b0;
          e1 = best(1);
          if (e0 != 0) pend_m[e0] = 1'b1;
          claim2(a, b);
          chk("R10 random ctx0", a, e0);
          chk("R10 random ctx1", b, e1);
        end else begin
          c = int'($urandom % 2);
          e0 = best(c);
          claim(c, v);
          chk(e0 == 0 ? "R6 random empty" : "R5 random claim", v, e0);
        end
      end
      for (int i = 1; i <= NSRC; i++)
        if (busy_m[i]) complete(en_m[0][i] ? 0 : 1, i);
      settle();
      e0 = best(0);
      claim(0, v);
      chk("R8 random after completions", v, e0);
    end

    finish_up();
  end

endmodule